// File: doc/BRIEF.md
# SGRAM Command Decoder

This block sits at the front of a graphics DRAM model. On every rising clock edge it samples the control pins: clock enable, chip select, the three strobes, the special-function pin, the bank select and address bit 8. It turns them into a registered one-hot command code, an auto-precharge flag, a per-bank mask and an illegal-command flag. The rest of the model reads these outputs and never looks at the raw pins. Each output appears one clock after the pins that produce it.

The special-function pin splits three ordinary SDRAM encodings into graphics variants:

- Mode load becomes special mode load.
- Activate becomes masked activate.
- Write becomes block write.

Address bit 8 requests auto precharge on column commands. On a precharge it widens the command to all banks.

Clock-enable handling is a small state machine with three states:

- `PWR_RUN`: normal operation. It moves to `PWR_PDOWN` when clock enable falls on a deselect or NOP. It moves to `PWR_SREF` when clock enable falls on a refresh pattern. In both cases the remaining pins are sampled on that same edge.
- `PWR_PDOWN`: power down. It returns to `PWR_RUN` on the first edge that sees clock enable high, which reports the power-down exit.
- `PWR_SREF`: self refresh. It returns to `PWR_RUN` the same way, which reports the self-refresh exit.

Any other command sampled while clock enable falls is flagged illegal and reported as NOP. The state does not change.

Top module: `sgram_cmd_decoder`

## Requirements
- R1: While reset is asserted and after it, until the first sampled command, `cmd_onehot` is bit 0 only (deselect). `bank_mask`, `auto_pre` and `cmd_illegal` are 0.
- R2: With clock enable high and `cs_n` high, the output one cycle later is deselect (bit 0). `bank_mask` is 0 and `auto_pre` is 0 whatever the other pins carry.
- R3: With `cs_n`, `ras_n`, `cas_n` and `we_n` all low, the command is mode load (bit 2) when `dsf` is 0 and special mode load (bit 3) when `dsf` is 1.
- R4: `ras_n` low with `cas_n` and `we_n` high is activate (bit 4) for `dsf` 0 and masked activate (bit 5) for `dsf` 1. `bank_mask` then has only bit `ba` set (bit 0 is bank A).
- R5: `ras_n` high and `cas_n` low is read (bit 6) when `we_n` is high. With `we_n` low it is write (bit 7) for `dsf` 0 and block write (bit 8) for `dsf` 1. On these three commands `auto_pre` equals `a8` and `bank_mask` has only bit `ba` set.
- R6: With `cs_n` low, strobes `ras_n`/`cas_n`/`we_n` = 1/1/0 give burst terminate (bit 9) and 1/1/1 give NOP (bit 1). Both carry a zero `bank_mask`.
- R7: Strobes 0/1/0 are precharge. With `a8` 0 it is single-bank precharge (bit 10) and `bank_mask` has only bit `ba` set. With `a8` 1 it is all-bank precharge (bit 11), `bank_mask` is all ones and `ba` is ignored.
- R8: Strobes 0/0/1 give auto refresh (bit 12) with clock enable high in both cycles. With clock enable high then low they give self-refresh entry (bit 13). While clock enable stays low, the output is deselect and all other pins are ignored. The first cycle with clock enable high gives self-refresh exit (bit 14).
- R9: Clock enable falling with deselect or NOP gives power-down entry (bit 15). While clock enable stays low, the output is deselect. The first cycle with clock enable high gives power-down exit (bit 16).
- R10: Clock enable falling with any other command sets `cmd_illegal` for that cycle and reports NOP (bit 1) with a zero mask. The block stays out of power down, so a later rising clock enable decodes the pins normally.
- R11: After reset exactly one bit of `cmd_onehot` is set every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| dsf | input | 1 | Special-function select |
| ba | input | BA_W | Bank select |
| a8 | input | 1 | Auto-precharge / all-bank qualifier |
| cmd_onehot | output | 17 | One-hot command code, bit order as in R1–R11 |
| auto_pre | output | 1 | Auto precharge requested by the column command |
| bank_mask | output | N_BANK | Banks the command addresses |
| cmd_illegal | output | 1 | Unsupported command seen; reported as NOP |

## Verification
The bench goes after the clock-enable edges:

- **Entry and exit.** It drives each low-power entry, a hold with junk on the pins, and the exit. A decoder that ignored the previous clock enable would report auto refresh or NOP instead of the entry codes. One that did not hold its state would decode the junk.
- **Refused suspend.** It drives a column command while clock enable falls. It then raises clock enable with a NOP; a design that wrongly entered power down would report an exit there.
- **Qualifier pins.** It pairs `a8` and `ba` values across read, write, block write and precharge. A swapped bank bit, or `a8` leaking into the mask of a column command, shows up directly in `bank_mask`.

// File: rtl/sgram_cmd_pkg.sv
package sgram_cmd_pkg;

    localparam int N_CMD = 17;

    typedef enum logic [4:0] {
        CMD_DESEL      = 5'd0,
        CMD_NOP        = 5'd1,
        CMD_MODE_LD    = 5'd2,
        CMD_SPMODE_LD  = 5'd3,
        CMD_ACT        = 5'd4,
        CMD_ACT_MASK   = 5'd5,
        CMD_READ       = 5'd6,
        CMD_WRITE      = 5'd7,
        CMD_BLKWR      = 5'd8,
        CMD_BURST_STOP = 5'd9,
        CMD_PRE_ONE    = 5'd10,
        CMD_PRE_ALL    = 5'd11,
        CMD_AUTO_REF   = 5'd12,
        CMD_SREF_ENTER = 5'd13,
        CMD_SREF_EXIT  = 5'd14,
        CMD_PDN_ENTER  = 5'd15,
        CMD_PDN_EXIT   = 5'd16
    } sg_cmd_e;

    typedef enum logic [1:0] {
        PWR_RUN   = 2'd0,
        PWR_PDOWN = 2'd1,
        PWR_SREF  = 2'd2
    } pwr_state_e;

endpackage

// File: rtl/sgram_pin_decode.sv
// Pure pattern decode of the strobes, assuming the clock stays enabled.
module sgram_pin_decode
    import sgram_cmd_pkg::*;
(
    input  logic    cs_n,
    input  logic    ras_n,
    input  logic    cas_n,
    input  logic    we_n,
    input  logic    dsf,
    input  logic    a8,
    output sg_cmd_e base_cmd,
    output logic    is_idle,
    output logic    is_refresh
);

    always_comb begin
        base_cmd   = CMD_NOP;
        is_idle    = 1'b0;
        is_refresh = 1'b0;
        if (cs_n) begin
            base_cmd = CMD_DESEL;
            is_idle  = 1'b1;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b000: base_cmd = dsf ? CMD_SPMODE_LD : CMD_MODE_LD;
                3'b001: begin
                    base_cmd   = CMD_AUTO_REF;
                    is_refresh = 1'b1;
                end
                3'b010: base_cmd = a8 ? CMD_PRE_ALL : CMD_PRE_ONE;
                3'b011: base_cmd = dsf ? CMD_ACT_MASK : CMD_ACT;
                3'b100: base_cmd = dsf ? CMD_BLKWR : CMD_WRITE;
                3'b101: base_cmd = CMD_READ;
                3'b110: base_cmd = CMD_BURST_STOP;
                3'b111: begin
                    base_cmd = CMD_NOP;
                    is_idle  = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/sgram_power_fsm.sv
// Tracks clock enable and the low-power state; picks the final command.
module sgram_power_fsm
    import sgram_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cke,
    input  sg_cmd_e    base_cmd,
    input  logic       is_idle,
    input  logic       is_refresh,
    output sg_cmd_e    cmd,
    output logic       illegal,
    output pwr_state_e pwr_state
);

    pwr_state_e state_q, state_d;
    logic       cke_prev_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= PWR_RUN;
            cke_prev_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            cke_prev_q <= cke;
        end
    end

    // next state and command
    always_comb begin
        state_d = state_q;
        cmd     = CMD_DESEL;
        illegal = 1'b0;
        unique case (state_q)
            PWR_RUN: begin
                if (cke) begin
                    cmd = base_cmd;
                end else if (!cke_prev_q) begin
                    cmd = CMD_DESEL;
                end else if (is_idle) begin
                    cmd     = CMD_PDN_ENTER;
                    state_d = PWR_PDOWN;
                end else if (is_refresh) begin
                    cmd     = CMD_SREF_ENTER;
                    state_d = PWR_SREF;
                end else begin
                    cmd     = CMD_NOP;
                    illegal = 1'b1;
                end
            end
            PWR_PDOWN: begin
                if (cke) begin
                    cmd     = CMD_PDN_EXIT;
                    state_d = PWR_RUN;
                end
            end
            PWR_SREF: begin
                if (cke) begin
                    cmd     = CMD_SREF_EXIT;
                    state_d = PWR_RUN;
                end
            end
            default: state_d = PWR_RUN;
        endcase
    end

    assign pwr_state = state_q;

    // R9: power down persists while clock enable stays low
    a_r9_pdown_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PWR_PDOWN && !cke) |=> (state_q == PWR_PDOWN));

    // R8: self refresh persists while clock enable stays low
    a_r8_sref_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PWR_SREF && !cke) |=> (state_q == PWR_SREF));

    // R10: a refused command never leaves the run state
    a_r10_illegal_stays_run: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> (state_q == PWR_RUN));

endmodule

// File: rtl/sgram_addr_qual.sv
// Derives bank mask and auto-precharge flag from the final command.
module sgram_addr_qual
    import sgram_cmd_pkg::*;
#(
    parameter int N_BANK = 2,
    localparam int BA_W  = (N_BANK > 1) ? $clog2(N_BANK) : 1
) (
    input  sg_cmd_e           cmd,
    input  logic [BA_W-1:0]   ba,
    input  logic              a8,
    output logic [N_BANK-1:0] bank_mask,
    output logic              auto_pre
);

    logic is_column;
    logic uses_ba;
    logic all_banks;

    always_comb begin
        is_column = (cmd == CMD_READ) || (cmd == CMD_WRITE) || (cmd == CMD_BLKWR);
        uses_ba   = is_column || (cmd == CMD_ACT) || (cmd == CMD_ACT_MASK)
                    || (cmd == CMD_PRE_ONE);
        all_banks = (cmd == CMD_PRE_ALL);
        auto_pre  = is_column && a8;
    end

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        assign bank_mask[b] = all_banks || (uses_ba && (ba == BA_W'(b)));
    end

endmodule

// File: rtl/sgram_cmd_decoder.sv
module sgram_cmd_decoder
    import sgram_cmd_pkg::*;
#(
    parameter int N_BANK = 2,
    localparam int BA_W  = (N_BANK > 1) ? $clog2(N_BANK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              dsf,
    input  logic [BA_W-1:0]   ba,
    input  logic              a8,
    output logic [N_CMD-1:0]  cmd_onehot,
    output logic              auto_pre,
    output logic [N_BANK-1:0] bank_mask,
    output logic              cmd_illegal
);

    sg_cmd_e           base_cmd;
    sg_cmd_e           cmd_d;
    logic              is_idle;
    logic              is_refresh;
    logic              illegal_d;
    pwr_state_e        pwr_state;
    logic [N_BANK-1:0] mask_d;
    logic              ap_d;
    logic [N_CMD-1:0]  onehot_d;

    sgram_pin_decode u_pins (
        .cs_n       (cs_n),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .dsf        (dsf),
        .a8         (a8),
        .base_cmd   (base_cmd),
        .is_idle    (is_idle),
        .is_refresh (is_refresh)
    );

    sgram_power_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke        (cke),
        .base_cmd   (base_cmd),
        .is_idle    (is_idle),
        .is_refresh (is_refresh),
        .cmd        (cmd_d),
        .illegal    (illegal_d),
        .pwr_state  (pwr_state)
    );

    sgram_addr_qual #(.N_BANK(N_BANK)) u_qual (
        .cmd       (cmd_d),
        .ba        (ba),
        .a8        (a8),
        .bank_mask (mask_d),
        .auto_pre  (ap_d)
    );

    for (genvar i = 0; i < N_CMD; i++) begin : g_onehot
        assign onehot_d[i] = (cmd_d == sg_cmd_e'(i));
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_onehot  <= N_CMD'(1);
            auto_pre    <= 1'b0;
            bank_mask   <= '0;
            cmd_illegal <= 1'b0;
        end else begin
            cmd_onehot  <= onehot_d;
            auto_pre    <= ap_d;
            bank_mask   <= mask_d;
            cmd_illegal <= illegal_d;
        end
    end

    // R11: exactly one command reported
    a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cmd_onehot) == 1);

    // R5: auto precharge only accompanies a column command
    a_r5_autopre_column: assert property (@(posedge clk) disable iff (!rst_n)
        auto_pre |-> (cmd_onehot[CMD_READ] || cmd_onehot[CMD_WRITE] || cmd_onehot[CMD_BLKWR]));

    // R7: all-bank precharge covers every bank
    a_r7_pre_all_mask: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_onehot[CMD_PRE_ALL] |-> (&bank_mask));

    // R10: an illegal command is reported as NOP
    a_r10_illegal_nop: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_illegal |-> (cmd_onehot[CMD_NOP] && bank_mask == '0));

    // R2: deselect addresses no bank
    a_r2_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_onehot[CMD_DESEL] |-> (bank_mask == '0 && !auto_pre));

    // R8: self-refresh exit follows only from the self-refresh state
    a_r8_exit_from_sref: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_onehot[CMD_SREF_EXIT]) |-> $past(pwr_state == PWR_SREF));

endmodule

// File: tb/sgram_cmd_decoder_bench.sv
module sgram_cmd_decoder_bench;

    localparam int NC = 17;

    localparam int DESEL = 0,  NOP = 1,  MLD = 2,  SMLD = 3,  ACT = 4,  ACTM = 5;
    localparam int RD    = 6,  WR  = 7,  BW  = 8,  BST  = 9,  PRE1 = 10, PREA = 11;
    localparam int REF   = 12, SRE = 13, SRX = 14, PDE  = 15, PDX  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic          dsf = 1'b0, a8 = 1'b0;
    logic [0:0]    ba = 1'b0;
    logic [NC-1:0] cmd_onehot;
    logic          auto_pre;
    logic [1:0]    bank_mask;
    logic          cmd_illegal;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    typedef struct {
        int       cmd;
        bit       ill;
        bit [1:0] mask;
        bit       ap;
        string    tag;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    sgram_cmd_decoder u_sgram_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .dsf(dsf), .ba(ba), .a8(a8),
        .cmd_onehot(cmd_onehot), .auto_pre(auto_pre), .bank_mask(bank_mask),
        .cmd_illegal(cmd_illegal)
    );

    task automatic compare(input exp_t e);
        logic [NC-1:0] want;
        want = NC'(1) << e.cmd;
        n_checks++;
        if (cmd_onehot !== want || cmd_illegal !== e.ill
            || bank_mask !== e.mask || auto_pre !== e.ap) begin
            n_fails++;
            $display("FAIL %s: got cmd=%h ill=%b mask=%b ap=%b, expected cmd=%h ill=%b mask=%b ap=%b",
                     e.tag, cmd_onehot, cmd_illegal, bank_mask, auto_pre,
                     want, e.ill, e.mask, e.ap);
        end
    endtask

    // monitor: one registered result per driven cycle
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) compare(sb.pop_front());
    end

    // driver: pins for one cycle plus the expected result
    task automatic cyc(input bit k, input bit cs, input bit r, input bit c,
                       input bit w, input bit d, input bit b, input bit a,
                       input int ec, input bit ei, input bit [1:0] em,
                       input bit ea, input string tag);
        exp_t e;
        @(negedge clk);
        cke = k; cs_n = cs; ras_n = r; cas_n = c; we_n = w; dsf = d; ba = b; a8 = a;
        e.cmd = ec; e.ill = ei; e.mask = em; e.ap = ea; e.tag = tag;
        sb.push_back(e);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got no end of stimulus, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        exp_t r1;
        repeat (3) @(negedge clk);
        r1.cmd = DESEL; r1.ill = 0; r1.mask = 2'b00; r1.ap = 0; r1.tag = "R1 reset";
        compare(r1);
        @(negedge clk);
        rst_n = 1'b1;

        //  k  cs r  c  w  d  b  a   cmd   ill mask   ap
        cyc(1, 1, 1, 1, 1, 0, 0, 0,  DESEL, 0, 2'b00, 0, "R1 first idle");
        cyc(1, 1, 0, 1, 0, 1, 1, 1,  DESEL, 0, 2'b00, 0, "R2 cs high junk");
        cyc(1, 0, 1, 1, 1, 0, 0, 0,  NOP,   0, 2'b00, 0, "R6 nop");
        cyc(1, 0, 0, 0, 0, 0, 0, 0,  MLD,   0, 2'b00, 0, "R3 mode load");
        cyc(1, 0, 0, 0, 0, 1, 1, 0,  SMLD,  0, 2'b00, 0, "R3 special mode load");
        cyc(1, 0, 0, 1, 1, 0, 1, 0,  ACT,   0, 2'b10, 0, "R4 activate B");
        cyc(1, 0, 0, 1, 1, 1, 0, 1,  ACTM,  0, 2'b01, 0, "R4 masked activate A");
        cyc(1, 0, 1, 0, 1, 0, 0, 1,  RD,    0, 2'b01, 1, "R5 read autopre A");
        cyc(1, 0, 1, 0, 0, 0, 1, 0,  WR,    0, 2'b10, 0, "R5 write B");
        cyc(1, 0, 1, 0, 0, 1, 1, 1,  BW,    0, 2'b10, 1, "R5 block write autopre B");
        cyc(1, 0, 1, 0, 1, 1, 1, 0,  RD,    0, 2'b10, 0, "R5 read B dsf high");
        cyc(1, 0, 1, 1, 0, 0, 1, 1,  BST,   0, 2'b00, 0, "R6 burst terminate");
        cyc(1, 0, 0, 1, 0, 0, 1, 0,  PRE1,  0, 2'b10, 0, "R7 precharge B");
        cyc(1, 0, 0, 1, 0, 0, 0, 0,  PRE1,  0, 2'b01, 0, "R7 precharge A");
        cyc(1, 0, 0, 1, 0, 0, 0, 1,  PREA,  0, 2'b11, 0, "R7 precharge all");
        cyc(1, 0, 0, 0, 1, 0, 0, 0,  REF,   0, 2'b00, 0, "R8 auto refresh");
        cyc(0, 0, 0, 0, 1, 0, 0, 0,  SRE,   0, 2'b00, 0, "R8 self refresh entry");
        cyc(0, 0, 1, 0, 1, 0, 1, 1,  DESEL, 0, 2'b00, 0, "R8 hold ignores read");
        cyc(0, 0, 0, 1, 1, 0, 0, 0,  DESEL, 0, 2'b00, 0, "R8 hold ignores act");
        cyc(1, 1, 1, 1, 1, 0, 0, 0,  SRX,   0, 2'b00, 0, "R8 self refresh exit");
        cyc(1, 0, 1, 1, 1, 0, 0, 0,  NOP,   0, 2'b00, 0, "R8 back to run");
        cyc(0, 1, 1, 1, 1, 0, 0, 0,  PDE,   0, 2'b00, 0, "R9 pdown entry deselect");
        cyc(0, 0, 0, 0, 0, 0, 0, 0,  DESEL, 0, 2'b00, 0, "R9 hold ignores mode load");
        cyc(1, 0, 1, 0, 1, 0, 0, 0,  PDX,   0, 2'b00, 0, "R9 pdown exit");
        cyc(0, 0, 1, 1, 1, 0, 0, 0,  PDE,   0, 2'b00, 0, "R9 pdown entry nop");
        cyc(1, 1, 1, 1, 1, 0, 0, 0,  PDX,   0, 2'b00, 0, "R9 pdown exit 2");
        cyc(0, 0, 1, 0, 1, 0, 1, 1,  NOP,   1, 2'b00, 0, "R10 suspend read illegal");
        cyc(0, 1, 1, 1, 1, 0, 0, 0,  DESEL, 0, 2'b00, 0, "R10 clock held");
        cyc(1, 0, 1, 1, 1, 0, 0, 0,  NOP,   0, 2'b00, 0, "R10 no pdown exit");
        cyc(1, 0, 0, 1, 1, 0, 1, 0,  ACT,   0, 2'b10, 0, "R10 normal decode after");
        cyc(0, 0, 0, 1, 0, 0, 0, 1,  NOP,   1, 2'b00, 0, "R10 suspend precharge illegal");
        cyc(1, 0, 0, 0, 1, 0, 0, 0,  REF,   0, 2'b00, 0, "R11 refresh after clock held");
        cyc(1, 1, 1, 1, 1, 0, 0, 0,  DESEL, 0, 2'b00, 0, "R2 final idle");

        repeat (3) @(posedge clk);
        #1;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule